// File: doc/BRIEF.md
# Byte-Lane Double-Rate Write Capture

This block collects write data from a 32-bit bus that is split into four byte lanes. Each lane has its own data strobe and its own byte mask. Data and masks are taken on both edges of a lane's strobe. Here that is modelled as a rise-phase and fall-phase sample pair, offered in one clock cycle together with a per-lane strobe pulse.

The block holds each lane's pair until all lanes have delivered theirs. It then releases one two-beat word to the storage array, with a byte enable for every byte of every beat. The command logic raises `wr_active` for the length of a write burst, and a length code picks how many beats the burst carries. The block passes on exactly that many beats. Strobes outside an active burst, and strobes that arrive after the burst has been filled, are dropped.

Top module: `ddr_wr_capture`

## Requirements
- R1: Lane k (k = 0..3) owns data bits [8k+7:8k] of both `dq_rise` and `dq_fall`. It is captured by strobe bit `dqs_pulse[k]` and masked by `dm_rise[k]` / `dm_fall[k]`.
- R2: `out_data[31:0]` carries the rise beat and `out_data[63:32]` the fall beat. When every lane has delivered its pair, `out_vld` is high for one cycle, in the cycle after the last lane's strobe.
- R3: Byte enables are the inverse of the mask sampled with the same beat, with no extra delay. `out_be[k]` = NOT `dm_rise[k]` and `out_be[4+k]` = NOT `dm_fall[k]`, where both mask bits are the ones captured with that lane's strobe.
- R4: A lane that strobes earlier than the others keeps its pair. The word is emitted in the cycle after the slowest lane strobes.
- R5: A lane that already holds a pair ignores further strobes, and the data and mask offered with them, until its word is released.
- R6: `len_code` is sampled in the first cycle of `wr_active`. Codes 0, 1, 2 and 3 select 2, 4, 8 and 16 beats, which is 1, 2, 4 and 8 words. Exactly that many words are emitted, and later strobes in the same burst are ignored.
- R7: `out_last` is high together with the final word of the burst and low on all other cycles.
- R8: While `wr_active` is low, strobes, data and masks have no effect and `out_vld` stays low. Pairs held when `wr_active` falls are discarded.
- R9: After reset, `out_vld` and `out_last` are low and no lane holds a pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_active | input | 1 | Write burst in progress, from command logic |
| len_code | input | 2 | Burst length select (2, 4, 8, 16 beats) |
| dqs_pulse | input | 4 | Per-lane strobe: a rise/fall pair is present this cycle |
| dq_rise | input | 32 | Data sampled on the rising strobe edge |
| dq_fall | input | 32 | Data sampled on the falling strobe edge |
| dm_rise | input | 4 | Byte masks sampled on the rising strobe edge |
| dm_fall | input | 4 | Byte masks sampled on the falling strobe edge |
| out_vld | output | 1 | Two-beat word valid |
| out_last | output | 1 | Final word of the burst |
| out_data | output | 64 | Fall beat in the upper half, rise beat in the lower half |
| out_be | output | 8 | Byte enables, fall beat in the upper nibble |

## Verification
The hardest situation to reach is one where lanes arrive out of step. One lane holds a pair, is offered a second strobe with different data before the slow lanes catch up, and the burst ends or `wr_active` drops while that lane still holds its pair. The stimulus staggers individual strobe bits across cycles on purpose. It re-strobes an already-held lane with fresh data and masks, drops `wr_active` with one lane half-filled, and then starts a new burst. A behavioural per-lane model predicts every output cycle, so a stale or leaked pair shows up as a data or enable mismatch.

// File: rtl/ddr_wcap_pkg.sv
package ddr_wcap_pkg;

   // number of two-beat words in a burst for a given length code
   function automatic int unsigned words_for_code(input int unsigned code);
      return 32'd1 << code;
   endfunction

   // largest word count selectable with a code of the given width
   function automatic int unsigned max_words(input int unsigned code_w);
      return 32'd1 << ((32'd1 << code_w) - 1);
   endfunction

endpackage

// File: rtl/ddr_wcap_lane.sv
module ddr_wcap_lane #(
   parameter int unsigned LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              open,
   input  logic              strobe,
   input  logic              rel,
   input  logic [LANE_W-1:0] d_rise,
   input  logic [LANE_W-1:0] d_fall,
   input  logic              m_rise,
   input  logic              m_fall,
   output logic              ready,
   output logic [LANE_W-1:0] o_d_rise,
   output logic [LANE_W-1:0] o_d_fall,
   output logic              o_be_rise,
   output logic              o_be_fall
);

   logic              held_q;
   logic [LANE_W-1:0] hr_q, hf_q;
   logic              mr_q, mf_q;
   logic              take;

   assign take  = strobe & open & ~held_q;
   assign ready = held_q | take;

   // held pair wins; otherwise the pair arriving this cycle passes straight through
   assign o_d_rise  = held_q ? hr_q : d_rise;
   assign o_d_fall  = held_q ? hf_q : d_fall;
   assign o_be_rise = ~(held_q ? mr_q : m_rise);
   assign o_be_fall = ~(held_q ? mf_q : m_fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         hr_q   <= '0;
         hf_q   <= '0;
         mr_q   <= 1'b0;
         mf_q   <= 1'b0;
      end else begin
         if (flush || rel) begin
            held_q <= 1'b0;
         end else if (take) begin
            held_q <= 1'b1;
         end
         if (take) begin
            hr_q <= d_rise;
            hf_q <= d_fall;
            mr_q <= m_rise;
            mf_q <= m_fall;
         end
      end
   end

   // R5: a held pair is not overwritten while waiting for the other lanes
   p_hold_keep_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (held_q && !rel && !flush) |=> (held_q && $stable(hr_q) && $stable(hf_q)
                                      && $stable(mr_q) && $stable(mf_q)));

   // R3: the stored mask is the one sampled with the strobe
   p_mask_keep_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (take && !rel && !flush) |=> (mr_q == $past(m_rise) && mf_q == $past(m_fall)));

   // R8: nothing is held after the burst window closes
   p_flush_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !held_q);

endmodule

// File: rtl/ddr_wcap_burst_ctr.sv
module ddr_wcap_burst_ctr
   import ddr_wcap_pkg::*;
#(
   parameter int unsigned LEN_CODE_W = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_active,
   input  logic [LEN_CODE_W-1:0] len_code,
   input  logic                  fire,
   output logic                  open,
   output logic                  last
);

   localparam int unsigned MAX_WORDS = max_words(LEN_CODE_W);
   localparam int unsigned LEFT_W    = $clog2(MAX_WORDS + 1);

   logic              act_q;
   logic              start;
   logic [LEFT_W-1:0] left_q, left_eff;

   assign start    = wr_active & ~act_q;
   assign left_eff = start ? LEFT_W'(words_for_code(32'(len_code))) : left_q;
   assign open     = wr_active & (left_eff != '0);
   assign last     = (left_eff == LEFT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         left_q <= '0;
      end else begin
         act_q <= wr_active;
         if (!wr_active) begin
            left_q <= '0;
         end else if (fire) begin
            left_q <= left_eff - LEFT_W'(1);
         end else begin
            left_q <= left_eff;
         end
      end
   end

   // R6: no word is released once the burst's word count is used up
   p_no_fire_closed_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> open);

   // R6: the remaining count never exceeds the largest burst
   p_left_bound_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      left_q <= LEFT_W'(MAX_WORDS));

endmodule

// File: rtl/ddr_wr_capture.sv
module ddr_wr_capture
   import ddr_wcap_pkg::*;
#(
   parameter int unsigned LANES      = 4,
   parameter int unsigned LANE_W     = 8,
   parameter int unsigned LEN_CODE_W = 2,
   parameter bit          REG_OUT    = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_active,
   input  logic [LEN_CODE_W-1:0]     len_code,
   input  logic [LANES-1:0]          dqs_pulse,
   input  logic [LANES*LANE_W-1:0]   dq_rise,
   input  logic [LANES*LANE_W-1:0]   dq_fall,
   input  logic [LANES-1:0]          dm_rise,
   input  logic [LANES-1:0]          dm_fall,
   output logic                      out_vld,
   output logic                      out_last,
   output logic [2*LANES*LANE_W-1:0] out_data,
   output logic [2*LANES-1:0]        out_be
);

   localparam int unsigned BUS_W = LANES * LANE_W;

   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (LANE_W < 1) begin : g_bad_width
      $error("LANE_W must be at least 1");
   end
   if (LEN_CODE_W < 1 || LEN_CODE_W > 3) begin : g_bad_code
      $error("LEN_CODE_W must be 1 to 3");
   end

   logic             open, last, fire;
   logic [LANES-1:0] ready;
   logic [BUS_W-1:0] word_r, word_f;
   logic [LANES-1:0] be_r, be_f;

   ddr_wcap_burst_ctr #(.LEN_CODE_W(LEN_CODE_W)) i_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_active(wr_active),
      .len_code (len_code),
      .fire     (fire),
      .open     (open),
      .last     (last)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      ddr_wcap_lane #(.LANE_W(LANE_W)) i_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .flush    (~wr_active),
         .open     (open),
         .strobe   (dqs_pulse[k]),
         .rel      (fire),
         .d_rise   (dq_rise[k*LANE_W +: LANE_W]),
         .d_fall   (dq_fall[k*LANE_W +: LANE_W]),
         .m_rise   (dm_rise[k]),
         .m_fall   (dm_fall[k]),
         .ready    (ready[k]),
         .o_d_rise (word_r[k*LANE_W +: LANE_W]),
         .o_d_fall (word_f[k*LANE_W +: LANE_W]),
         .o_be_rise(be_r[k]),
         .o_be_fall(be_f[k])
      );
   end

   assign fire = &ready;

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_vld  <= 1'b0;
            out_last <= 1'b0;
            out_data <= '0;
            out_be   <= '0;
         end else begin
            out_vld  <= fire;
            out_last <= fire & last;
            if (fire) begin
               out_data <= {word_f, word_r};
               out_be   <= {be_f, be_r};
            end
         end
      end

      // R8: a word only follows a cycle inside the write window
      p_idle_quiet_r8 : assert property (@(posedge clk) disable iff (!rst_n)
         out_vld |-> $past(wr_active));
   end else begin : g_comb_out
      assign out_vld  = fire;
      assign out_last = fire & last;
      assign out_data = {word_f, word_r};
      assign out_be   = {be_f, be_r};
   end

   // R7: the last marker never stands alone
   p_last_with_vld_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_vld);

endmodule

// File: tb/test_ddr_wr_capture.sv
module test_ddr_wr_capture;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_active = 1'b0;
   logic [1:0]  len_code = '0;
   logic [3:0]  dqs_pulse = '0;
   logic [31:0] dq_rise = '0, dq_fall = '0;
   logic [3:0]  dm_rise = '0, dm_fall = '0;
   logic        out_vld, out_last;
   logic [63:0] out_data;
   logic [7:0]  out_be;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   ddr_wr_capture i_ddr_wr_capture (
      .clk(clk), .rst_n(rst_n), .wr_active(wr_active), .len_code(len_code),
      .dqs_pulse(dqs_pulse), .dq_rise(dq_rise), .dq_fall(dq_fall),
      .dm_rise(dm_rise), .dm_fall(dm_fall), .out_vld(out_vld),
      .out_last(out_last), .out_data(out_data), .out_be(out_be));

   // stimulus staged by the scenarios
   logic        v_act = 1'b0;
   logic [1:0]  v_code = '0;
   logic [3:0]  v_stb = '0;
   logic [31:0] v_dr = '0, v_df = '0;
   logic [3:0]  v_mr = '0, v_mf = '0;

   // behavioural model state
   bit        m_held[4];
   bit [7:0]  m_r[4], m_f[4];
   bit        m_mr[4], m_mf[4];
   int        m_left = 0;
   bit        m_act_q = 1'b0;
   bit        e_vld = 1'b0, e_last = 1'b0;
   bit [63:0] e_data = '0;
   bit [7:0]  e_be = '0;
   string     e_tag = "R9";

   task automatic check(input string tag, input string what,
                        input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic compare();
      check(e_tag, "out_vld", 64'(out_vld), 64'(e_vld));
      check(e_tag, "out_last", 64'(out_last), 64'(e_last));
      if (e_vld) begin
         check(e_tag, "out_data", out_data, e_data);
         check(e_tag, "out_be", 64'(out_be), 64'(e_be));
      end
   endtask

   // one cycle: check the previous prediction, apply new inputs, predict
   task automatic step(input string tag);
      int  lefte;
      bit  rdy[4];
      bit  fire;
      @(negedge clk);
      compare();
      wr_active = v_act; len_code = v_code; dqs_pulse = v_stb;
      dq_rise = v_dr; dq_fall = v_df; dm_rise = v_mr; dm_fall = v_mf;
      e_tag  = tag;
      e_vld  = 1'b0;
      e_last = 1'b0;
      lefte  = (v_act && !m_act_q) ? (1 << v_code) : m_left;
      if (!v_act) begin
         for (int k = 0; k < 4; k++) m_held[k] = 1'b0;
      end else begin
         fire = 1'b1;
         for (int k = 0; k < 4; k++) begin
            rdy[k] = m_held[k] || (v_stb[k] && lefte > 0);
            if (!rdy[k]) fire = 1'b0;
         end
         if (fire) begin
            e_vld  = 1'b1;
            e_last = (lefte == 1);
            for (int k = 0; k < 4; k++) begin
               e_data[8*k +: 8]      = m_held[k] ? m_r[k] : v_dr[8*k +: 8];
               e_data[32+8*k +: 8]   = m_held[k] ? m_f[k] : v_df[8*k +: 8];
               e_be[k]               = ~(m_held[k] ? m_mr[k] : v_mr[k]);
               e_be[4+k]             = ~(m_held[k] ? m_mf[k] : v_mf[k]);
               m_held[k]             = 1'b0;
            end
            lefte--;
         end else begin
            for (int k = 0; k < 4; k++) begin
               if (!m_held[k] && v_stb[k] && lefte > 0) begin
                  m_held[k] = 1'b1;
                  m_r[k] = v_dr[8*k +: 8]; m_f[k] = v_df[8*k +: 8];
                  m_mr[k] = v_mr[k];       m_mf[k] = v_mf[k];
               end
            end
         end
      end
      m_left  = v_act ? lefte : 0;
      m_act_q = v_act;
   endtask

   task automatic new_data();
      v_dr = $urandom; v_df = $urandom;
      v_mr = 4'($urandom); v_mf = 4'($urandom);
   endtask

   task automatic idle(input string tag, input int n);
      v_act = 1'b0; v_stb = '0;
      for (int i = 0; i < n; i++) step(tag);
   endtask

   // aligned strobes on all lanes for n cycles within one burst
   task automatic aligned(input string tag, input logic [1:0] code, input int n);
      v_act = 1'b1; v_code = code;
      for (int i = 0; i < n; i++) begin
         new_data();
         v_stb = 4'hF;
         step(tag);
      end
      idle(tag, 2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9", "out_vld in reset", 64'(out_vld), 64'd0);
      check("R9", "out_last in reset", 64'(out_last), 64'd0);
      rst_n = 1'b1;
      idle("R9", 2);

      // R1 R2 R3: fixed patterns make lane mapping and mask inversion visible
      v_act = 1'b1; v_code = 2'd1;
      v_dr = 32'h44332211; v_df = 32'h88776655; v_mr = 4'b0101; v_mf = 4'b1000;
      v_stb = 4'hF; step("R1");
      v_dr = 32'hDDCCBBAA; v_df = 32'h01020304; v_mr = 4'b0000; v_mf = 4'b1111;
      step("R3");
      idle("R2", 2);

      // R6 R7: every length code, with surplus strobes that must be dropped
      aligned("R6", 2'd0, 3);
      aligned("R6", 2'd1, 4);
      aligned("R7", 2'd2, 6);
      aligned("R6", 2'd3, 10);

      // R4: staggered lanes
      v_act = 1'b1; v_code = 2'd2;
      new_data(); v_stb = 4'b0100; step("R4");
      new_data(); v_stb = 4'b0001; step("R4");
      v_stb = 4'b0000; step("R4");
      new_data(); v_stb = 4'b1010; step("R4");
      new_data(); v_stb = 4'b1111; step("R4");
      v_stb = 4'b0000; step("R4");
      new_data(); v_stb = 4'b0011; step("R4");
      new_data(); v_stb = 4'b1100; step("R4");
      idle("R4", 2);

      // R5: held lanes re-strobed with different data and masks
      v_act = 1'b1; v_code = 2'd1;
      new_data(); v_stb = 4'b0011; step("R5");
      new_data(); v_stb = 4'b0111; step("R5");
      new_data(); v_stb = 4'b1111; step("R5");
      new_data(); v_stb = 4'b1111; step("R5");
      idle("R5", 2);

      // R8: activity with the window closed, then a half-filled word dropped
      v_act = 1'b0;
      for (int i = 0; i < 3; i++) begin new_data(); v_stb = 4'hF; step("R8"); end
      v_act = 1'b1; v_code = 2'd0;
      new_data(); v_stb = 4'b0110; step("R8");
      v_act = 1'b0; new_data(); v_stb = 4'b1001; step("R8");
      v_act = 1'b1; new_data(); v_stb = 4'b1111; step("R8");
      idle("R8", 2);

      // mixed gaps, R2 timing with idle cycles inside a burst
      v_act = 1'b1; v_code = 2'd2;
      for (int i = 0; i < 12; i++) begin
         new_data(); v_stb = (i % 3 == 2) ? 4'b0000 : 4'($urandom);
         step("R2");
      end
      idle("R2", 3);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule